// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Crossover Delay

This block is the digital control for one full bridge of a motor driver. Two command bits pick one of four bridge states: off, forward, reverse and brake. It decodes them into four registered gate enables, one source and one sink transistor for each of the two half-bridges (legs A and B). A per-leg timer keeps both transistors of a leg off for a set number of cycles whenever conduction passes from the source to the sink or back. This stops shoot-through current.

A chop input from the peak-current limiter removes the conducting source during a limiter off-time. Once the crossover delay on that leg has run out, the sink on the same leg is switched on. The winding current then recirculates through both low-side transistors (slow decay with synchronous rectification). Three global conditions force every gate off at the next clock edge: the active-low sleep input, an undervoltage flag and an over-temperature flag. After reset, and after sleep is released, commands are ignored for a settling window of `WAKE_CYC` cycles.

A stepper or dual-motor driver uses two instances, one per winding.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: Command `in_a=0, in_b=0` turns all four gates off one clock edge later.
- R2: Command `in_a=1, in_b=0` (forward) settles to source A and sink B on. Command `in_a=0, in_b=1` (reverse) settles to sink A and source B on. The gate vector {src_a, snk_a, src_b, snk_b} is 1001 for forward and 0110 for reverse.
- R3: Command `in_a=1, in_b=1` (brake) settles to both sinks on and both sources off (0101). `chop` has no effect in brake, and neither source is on in the cycle after a brake command is sampled.
- R4: While `chop` is high in forward or reverse, the source is off from the next edge onward. The sink on the same leg then turns on after the crossover delay, and the sink on the other leg stays on, so the steady vector is 0101.
- R5: When a leg hands conduction between its source and its sink, in either direction, both of its gates stay off for exactly `DEAD_CYC` cycles. The incoming gate rises on the `DEAD_CYC`-th edge after the outgoing gate fell.
- R6: A gate that comes back on the same leg with no opposite gate in between turns on at the next edge with no crossover delay. An example is a source restored after a chop pulse that ended before the sink could turn on.
- R7: The source and sink enables of a leg are never both high in any cycle.
- R8: `uvlo` or `over_temp` high, or `sleep_n` low, forces all gates off at the next edge. When the condition clears (sleep excepted, see R9), the commanded state returns at the next edge.
- R9: After reset is released, or after `sleep_n` rises, all gates stay off for `WAKE_CYC` edges. The commanded gates may turn on at edge `WAKE_CYC+1`.
- R10: During reset all gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_n | input | 1 | Low puts the bridge to sleep; rising edge starts the settling window |
| uvlo | input | 1 | Supply undervoltage flag, active high |
| over_temp | input | 1 | Thermal shutdown flag, active high |
| in_a | input | 1 | Command bit A |
| in_b | input | 1 | Command bit B |
| chop | input | 1 | Current-limiter off-time request, active high |
| src_a | output | 1 | Leg A high-side gate enable |
| snk_a | output | 1 | Leg A low-side gate enable |
| src_b | output | 1 | Leg B high-side gate enable |
| snk_b | output | 1 | Leg B low-side gate enable |

## Verification
The properties assume that every input is synchronous to `clk` and settles before each edge. They also assume `chop` comes from logic running on the same clock, and that `DEAD_CYC` is at least one. The bench changes inputs only on falling clock edges and holds each pattern long enough for any pending crossover delay and settling window to finish before a steady-state check. For the dead-time checks, it switches commands directly from one bridge state to another, so the hand-overs between a leg's source and sink are exercised without an intermediate off state.

// File: rtl/hbd_pkg.sv
// Shared types for the H-bridge gate sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package hbd_pkg;

    // Which transistor of a leg conducted most recently.
    typedef enum logic [1:0] {
        LAST_NONE = 2'd0,
        LAST_SRC  = 2'd1,
        LAST_SNK  = 2'd2
    } last_e;

    // Gate request of one leg, before crossover timing is applied.
    typedef struct packed {
        logic src;
        logic snk;
    } leg_req_t;

    localparam int LEG_A = 0;
    localparam int LEG_B = 1;
    localparam int NUM_LEGS = 2;

endpackage

// File: rtl/hbd_decode.sv
// Command decoder: maps the two command bits and the chop request to the
// gate request of each leg. The output is combinational and contains no timing.
// Assumes: inputs already synchronous to the block clock.
module hbd_decode
    import hbd_pkg::*;
(
    input  logic     in_a,
    input  logic     in_b,
    input  logic     chop,
    output leg_req_t req_a,
    output leg_req_t req_b
);

    // Truth table: off / forward / reverse / brake, with chop turning the
    // driving source into the same-leg sink (slow-decay recirculation).
    always_comb begin
        req_a = '0;
        req_b = '0;
        unique case ({in_a, in_b})
            2'b10: begin
                req_a.src = ~chop;
                req_a.snk = chop;
                req_b.snk = 1'b1;
            end
            2'b01: begin
                req_a.snk = 1'b1;
                req_b.src = ~chop;
                req_b.snk = chop;
            end
            2'b11: begin
                req_a.snk = 1'b1;
                req_b.snk = 1'b1;
            end
            default: begin
                req_a = '0;
                req_b = '0;
            end
        endcase
    end

endmodule

// File: rtl/hbd_wake.sv
// Settling window: holds ready low for WAKE_CYC edges after reset release
// or after sleep_n rises, and whenever sleep_n is low.
// Assumes: WAKE_CYC >= 1.
module hbd_wake #(
    parameter int WAKE_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    output logic ready
);

    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_END = WW'(WAKE_CYC);

    logic [WW-1:0] wcnt;

    // Count awake cycles up to the window length; restart while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n) begin
            wcnt <= '0;
        end else if (wcnt != WAKE_END) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // Ready once the full window has elapsed with sleep released.
    always_comb begin
        ready = sleep_n && (wcnt == WAKE_END);
    end

endmodule

// File: rtl/hbd_leg.sv
// One half-bridge leg: registers the source and sink enables and enforces
// a crossover gap of DEAD_CYC cycles whenever conduction passes between
// the two transistors. A transistor that returns after itself turns on at
// once. Removal of a gate is never delayed.
// Assumes: req_src and req_snk are never both high; DEAD_CYC >= 1.
module hbd_leg
    import hbd_pkg::*;
#(
    parameter int DEAD_CYC = 85
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req_src,
    input  logic req_snk,
    output logic src_q,
    output logic snk_q
);

    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(DEAD_CYC - 1);

    logic [CW-1:0] gap_cnt;
    last_e         last_q;
    logic          want_src, want_snk;
    logic          block_src, block_snk;
    logic          nxt_src, nxt_snk;
    logic          drop;

    // Next gate state: grant a request only if the opposite device is off
    // and, when it was the last to conduct, the gap has run out.
    always_comb begin
        want_src  = en & req_src;
        want_snk  = en & req_snk;
        block_src = snk_q | ((last_q == LAST_SNK) && (gap_cnt != '0));
        block_snk = src_q | ((last_q == LAST_SRC) && (gap_cnt != '0));
        nxt_src   = want_src & (src_q | ~block_src);
        nxt_snk   = want_snk & (snk_q | ~block_snk);
        drop      = (src_q & ~nxt_src) | (snk_q & ~nxt_snk);
    end

    // Gate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            snk_q <= 1'b0;
        end else begin
            src_q <= nxt_src;
            snk_q <= nxt_snk;
        end
    end

    // Crossover gap timer: reloads when a gate drops, then counts to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (drop) begin
            gap_cnt <= GAP_LOAD;
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // Remember which device conducted last, updated as it turns off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_NONE;
        end else if (src_q && !nxt_src) begin
            last_q <= LAST_SRC;
        end else if (snk_q && !nxt_snk) begin
            last_q <= LAST_SNK;
        end
    end

endmodule

// File: rtl/hbridge_gate_ctrl.sv
// Top of the H-bridge gate sequencer: command decode, settling window,
// global gate kill and two crossover-timed legs.
// Assumes: all inputs synchronous to clk; DEAD_CYC >= 1; WAKE_CYC >= 1.
module hbridge_gate_ctrl
    import hbd_pkg::*;
#(
    parameter int DEAD_CYC = 85,
    parameter int WAKE_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    input  logic uvlo,
    input  logic over_temp,
    input  logic in_a,
    input  logic in_b,
    input  logic chop,
    output logic src_a,
    output logic snk_a,
    output logic src_b,
    output logic snk_b
);

    leg_req_t                req_a, req_b;
    leg_req_t [NUM_LEGS-1:0] req_v;
    logic     [NUM_LEGS-1:0] src_v, snk_v;
    logic                    ready;
    logic                    gate_en;

    hbd_decode u_dec (
        .in_a  (in_a),
        .in_b  (in_b),
        .chop  (chop),
        .req_a (req_a),
        .req_b (req_b)
    );

    hbd_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_n (sleep_n),
        .ready   (ready)
    );

    // Global enable: settled, and no supply or thermal fault.
    always_comb begin
        gate_en = ready & ~uvlo & ~over_temp;
        req_v[LEG_A] = req_a;
        req_v[LEG_B] = req_b;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbd_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (gate_en),
            .req_src (req_v[g].src),
            .req_snk (req_v[g].snk),
            .src_q   (src_v[g]),
            .snk_q   (snk_v[g])
        );
    end

    // Map leg vectors to named outputs.
    always_comb begin
        src_a = src_v[LEG_A];
        snk_a = snk_v[LEG_A];
        src_b = src_v[LEG_B];
        snk_b = snk_v[LEG_B];
    end

endmodule

// File: rtl/hbd_checker.sv
// Property checker for hbridge_gate_ctrl, attached through bind.
// Keeps its own gap and settling counters so that long windows are not
// unrolled into delays.
// Assumes: inputs synchronous to clk; DEAD_CYC >= 1.
module hbd_checker #(
    parameter int DEAD_CYC = 85,
    parameter int WAKE_CYC = 300000
) (
    input logic clk,
    input logic rst_n,
    input logic sleep_n,
    input logic uvlo,
    input logic over_temp,
    input logic in_a,
    input logic in_b,
    input logic chop,
    input logic src_a,
    input logic snk_a,
    input logic src_b,
    input logic snk_b
);

    localparam int CW = $clog2(DEAD_CYC + 2);
    localparam int WW = $clog2(WAKE_CYC + 1);

    logic [1:0]    src_v, snk_v;
    logic [CW-1:0] off_cnt [2];
    logic [1:0]    last_snk, last_src;
    logic [WW-1:0] wk;

    always_comb begin
        src_v = {src_b, src_a};
        snk_v = {snk_b, snk_a};
    end

    // Settling-window mirror counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n) wk <= '0;
        else if (wk != WW'(WAKE_CYC)) wk <= wk + 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_chk
        // Cycles with both gates of the leg off, and last conductor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_cnt[g]  <= '0;
                last_snk[g] <= 1'b0;
                last_src[g] <= 1'b0;
            end else begin
                if (src_v[g] || snk_v[g]) off_cnt[g] <= '0;
                else if (off_cnt[g] != CW'(DEAD_CYC + 1)) off_cnt[g] <= off_cnt[g] + 1'b1;
                if (snk_v[g]) begin
                    last_snk[g] <= 1'b1;
                    last_src[g] <= 1'b0;
                end else if (src_v[g]) begin
                    last_snk[g] <= 1'b0;
                    last_src[g] <= 1'b1;
                end
            end
        end

        p_leg_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(src_v[g] && snk_v[g]));

        p_dead_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(src_v[g]) && last_snk[g]) |-> (off_cnt[g] >= CW'(DEAD_CYC)));

        p_dead_snk_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(snk_v[g]) && last_src[g]) |-> (off_cnt[g] >= CW'(DEAD_CYC)));
    end

    p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_a && !in_b) |=> !(src_a || snk_a || src_b || snk_b));

    p_brake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a && in_b) |=> !(src_a || src_b));

    p_chop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chop |=> !(src_a || src_b));

    p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo || over_temp || !sleep_n) |=> !(src_a || snk_a || src_b || snk_b));

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wk != WW'(WAKE_CYC)) |=> !(src_a || snk_a || src_b || snk_b));

endmodule

bind hbridge_gate_ctrl hbd_checker #(
    .DEAD_CYC(DEAD_CYC),
    .WAKE_CYC(WAKE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_n   (sleep_n),
    .uvlo      (uvlo),
    .over_temp (over_temp),
    .in_a      (in_a),
    .in_b      (in_b),
    .chop      (chop),
    .src_a     (src_a),
    .snk_a     (snk_a),
    .src_b     (src_b),
    .snk_b     (snk_b)
);

// File: tb/tb_hbridge_gate_ctrl.sv
// Self-checking bench: steady-state vector table, then directed timing tests.
module tb_hbridge_gate_ctrl;

    localparam int DEAD = 4;
    localparam int WAKE = 20;
    localparam int SETTLE = 16;
    localparam int NVEC = 11;

    // {in_a, in_b, chop, src_a, snk_a, src_b, snk_b}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b000_0000,  // R1 off
        7'b100_1001,  // R2 forward
        7'b101_0101,  // R4 chop forward
        7'b100_1001,  // R2 forward again
        7'b010_0110,  // R2 reverse
        7'b011_0101,  // R4 chop reverse
        7'b110_0101,  // R3 brake
        7'b111_0101,  // R3 brake, chop ignored
        7'b000_0000,  // R1 off
        7'b010_0110,  // R2 reverse from off
        7'b100_1001   // R2 forward from reverse
    };

    logic clk = 1'b0;
    logic rst_n, sleep_n, uvlo, over_temp, in_a, in_b, chop;
    logic src_a, snk_a, src_b, snk_b;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(DEAD), .WAKE_CYC(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uvlo(uvlo),
        .over_temp(over_temp), .in_a(in_a), .in_b(in_b), .chop(chop),
        .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b)
    );

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {src_a, snk_a, src_b, snk_b};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: gates=%b expected=%b", tag, act, exp);
        end
    endtask

    // Advance n rising edges, then stop at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic a, input logic b, input logic c);
        in_a = a; in_b = b; chop = c;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sleep_n = 1'b1; uvlo = 1'b0; over_temp = 1'b0;
        cmd(1'b1, 1'b0, 1'b0);
        step(3);
        check(4'b0000, "R10 reset state");
        rst_n = 1'b1;
        step(WAKE);
        check(4'b0000, "R9 commands ignored after reset");
        step(1);
        check(4'b1001, "R9 forward after settling window");

        for (int i = 0; i < NVEC; i++) begin
            cmd(VEC[i][6], VEC[i][5], VEC[i][4]);
            step(SETTLE);
            check(VEC[i][3:0], $sformatf("R2 R3 R4 R1 table row %0d", i));
        end

        // R5: forward to reverse, leg A source to sink hand-over.
        cmd(1'b0, 1'b1, 1'b0);
        step(1);
        check(4'b0000, "R5 both legs off after hand-over edge");
        step(DEAD - 1);
        check(4'b0000, "R5 still off one edge before gap ends");
        step(1);
        check(4'b0110, "R5 reverse gates on at DEAD edge");

        // R5 and R4: chop in reverse, same-leg sink after gap.
        cmd(1'b0, 1'b1, 1'b1);
        step(DEAD);
        check(4'b0100, "R4 source off, same-leg sink waits");
        step(1);
        check(4'b0101, "R4 slow-decay sinks on after gap");

        // R5: chop release, sink to source after gap.
        cmd(1'b0, 1'b1, 1'b0);
        step(DEAD);
        check(4'b0100, "R5 source waits after sink drops");
        step(1);
        check(4'b0110, "R5 source back after gap");

        // R6: short chop pulse, source returns with no gap.
        cmd(1'b0, 1'b1, 1'b1);
        step(1);
        check(4'b0100, "R6 chop removes source");
        cmd(1'b0, 1'b1, 1'b0);
        step(1);
        check(4'b0110, "R6 source restored at once");

        // R8: faults kill gates and release at the next edge.
        cmd(1'b1, 1'b0, 1'b0);
        step(SETTLE);
        uvlo = 1'b1;
        step(1);
        check(4'b0000, "R8 undervoltage forces off");
        uvlo = 1'b0;
        step(1);
        check(4'b1001, "R8 undervoltage release");
        over_temp = 1'b1;
        step(1);
        check(4'b0000, "R8 over-temperature forces off");
        over_temp = 1'b0;
        step(1);
        check(4'b1001, "R8 over-temperature release");

        // R9: sleep and wake window.
        sleep_n = 1'b0;
        step(1);
        check(4'b0000, "R8 sleep forces off");
        step(5);
        sleep_n = 1'b1;
        step(WAKE);
        check(4'b0000, "R9 commands ignored after wake");
        step(1);
        check(4'b1001, "R9 forward after wake window");

        // R3: brake straight from forward.
        cmd(1'b1, 1'b1, 1'b0);
        step(1);
        check(4'b0001, "R3 sources off after brake edge");
        step(SETTLE);
        check(4'b0101, "R3 brake steady");

        finish_run();
    end

endmodule